// File: doc/BRIEF.md
# TMDS Double-Data-Rate Symbol Gearbox

This block sits between a TMDS encoder and the double-data-rate output cells of a video link. It runs entirely in the fast serialization clock, which is five times the pixel clock and phase-aligned to it. A 10-bit symbol arrives for each of the three colour channels once per pixel period. The block cuts each symbol into five 2-bit pairs and presents one pair per fast cycle on its lane. Each DDR cell sends one bit on the rising edge and one on the falling edge. A fourth lane carries the link clock as a fixed symbol.

The symbol input is a valid/ready port. `sym_ready` is high for one fast cycle in every five, the last cycle of a pair sequence. A symbol is taken on the edge where `sym_valid` and `sym_ready` are both high. The producer cannot stall the gearbox, because the output line never pauses. If `sym_valid` is low in the ready cycle, the previous symbol is sent again. Input values in cycles where `sym_ready` is low have no effect. Until the first symbol is taken, every lane sends ones on both bits, which matches the power-up state of the output cells.

Top module: `tmds_ddr_gearbox`

## Requirements
- R1: `sym_ready` is high in exactly one fast cycle out of five. After reset is released, it first rises in the fifth cycle, and then appears every fifth cycle.
- R2: A symbol is captured only on the edge where `sym_valid` and `sym_ready` are both high. `sym_valid` and symbol values in cycles where `sym_ready` is low have no effect on any lane.
- R3: In the k-th cycle after a capture (k = 0..4), each data lane shows bits 2k+1 and 2k of its symbol. Lane bit 0 carries symbol bit 2k and lane bit 1 carries symbol bit 2k+1, so the least significant pair goes out first.
- R4: After reset, and until the first capture, all four lanes drive 2'b11.
- R5: After the first capture, the clock lane repeats the symbol 10'b1111100000 once per five-cycle period. Under the R3 ordering it shows the pairs 00, 00, 10, 11, 11.
- R6: When `sym_valid` is low in a ready cycle, each data lane repeats the symbol it sent in the previous period.
- R7: A reset asserted mid-stream returns the lanes to 2'b11 and holds `sym_ready` low. After release, timing restarts as in R1.
- R8: Each data lane carries only its own channel's symbol: blue, green and red are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Serialization clock, five times the pixel clock |
| rst_fast | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Symbol triple present |
| sym_ready | output | 1 | Capture slot, one cycle in five |
| sym_blue | input | 10 | Encoded blue symbol |
| sym_green | input | 10 | Encoded green symbol |
| sym_red | input | 10 | Encoded red symbol |
| lane_blue | output | 2 | Blue pair to DDR cell, bit 0 first |
| lane_green | output | 2 | Green pair to DDR cell, bit 0 first |
| lane_red | output | 2 | Red pair to DDR cell, bit 0 first |
| lane_clk | output | 2 | Link clock pair to DDR cell |

## Verification
Each lane is rebuilt into a 10-bit word from the five pairs that follow each ready cycle. These words are compared with symbols chosen so that the channels differ from one another. Walking-one and alternating patterns show whether pairs are out of order or swapped within a pair. Distinct values per channel show whether lanes are crossed. Junk data and random valid levels outside the ready cycle show whether capture is gated by the slot. Idle slots before and after the first capture separate the all-ones start state from repetition of the held symbol. A mid-stream reset shows that the lanes return to ones and that the slot timing restarts.

// File: rtl/tmds_gear_pkg.sv
package tmds_gear_pkg;
  // Lane order inside the gearbox; data channels come first
  typedef enum int unsigned {
    LANE_BLUE  = 0,
    LANE_GREEN = 1,
    LANE_RED   = 2,
    LANE_CLK   = 3
  } lane_e;

  localparam int unsigned N_DATA_LANES = 3;
  localparam int unsigned N_LANES      = N_DATA_LANES + 1;
  localparam int unsigned PAIR_W       = 2;
endpackage

// File: rtl/tmds_gear_phase.sv
module tmds_gear_phase #(
  parameter int unsigned PAIRS = 5,
  localparam int unsigned PH_W = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            last
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PAIRS - 1);

  always_ff @(posedge clk) begin
    if (rst)                phase <= '0;
    else if (phase == LAST_PH) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign last = (phase == LAST_PH);

  assert_phase_range_R1: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST_PH);
  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    last |=> (phase == '0));
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
    !last |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/tmds_gear_lane.sv
module tmds_gear_lane #(
  parameter int unsigned SYM_W = 10,
  localparam int unsigned PAIRS = SYM_W / 2,
  localparam int unsigned PH_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PH_W-1:0]  phase,
  input  logic [SYM_W-1:0] sym_in,
  output logic [1:0]       pair
);
  logic [SYM_W-1:0] hold;
  logic             loaded;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold   <= '1;
      loaded <= 1'b0;
    end else if (load) begin
      hold   <= sym_in;
      loaded <= 1'b1;
    end
  end

  // Pair k = {bit 2k+1, bit 2k}; idle ones until a symbol is held
  always_comb begin
    if (loaded) pair = hold[{phase, 1'b0} +: 2];
    else        pair = 2'b11;
  end

  assert_first_pair_R3: assert property (@(posedge clk) disable iff (rst)
    $past(load) |-> (pair == $past(sym_in[1:0])));
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(hold));
endmodule

// File: rtl/tmds_ddr_gearbox.sv
module tmds_ddr_gearbox
  import tmds_gear_pkg::*;
#(
  parameter int unsigned SYM_W = 10
) (
  input  logic             clk_fast,
  input  logic             rst_fast,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [SYM_W-1:0] sym_blue,
  input  logic [SYM_W-1:0] sym_green,
  input  logic [SYM_W-1:0] sym_red,
  output logic [1:0]       lane_blue,
  output logic [1:0]       lane_green,
  output logic [1:0]       lane_red,
  output logic [1:0]       lane_clk
);
  localparam int unsigned PAIRS = SYM_W / 2;
  localparam int unsigned PH_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int unsigned HALF  = SYM_W / 2;
  localparam logic [SYM_W-1:0] CLK_SYM = {{(SYM_W-HALF){1'b1}}, {HALF{1'b0}}};

  logic [PH_W-1:0]  phase;
  logic             slot;
  logic             take;
  logic [SYM_W-1:0] sym_arr  [N_LANES];
  logic [1:0]       pair_arr [N_LANES];

  tmds_gear_phase #(.PAIRS(PAIRS)) u_phase (
    .clk   (clk_fast),
    .rst   (rst_fast),
    .phase (phase),
    .last  (slot)
  );

  assign sym_ready = slot & ~rst_fast;
  assign take      = sym_valid & sym_ready;

  assign sym_arr[LANE_BLUE]  = sym_blue;
  assign sym_arr[LANE_GREEN] = sym_green;
  assign sym_arr[LANE_RED]   = sym_red;
  assign sym_arr[LANE_CLK]   = CLK_SYM;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    tmds_gear_lane #(.SYM_W(SYM_W)) u_lane (
      .clk    (clk_fast),
      .rst    (rst_fast),
      .load   (take),
      .phase  (phase),
      .sym_in (sym_arr[g]),
      .pair   (pair_arr[g])
    );
  end

  assign lane_blue  = pair_arr[LANE_BLUE];
  assign lane_green = pair_arr[LANE_GREEN];
  assign lane_red   = pair_arr[LANE_RED];
  assign lane_clk   = pair_arr[LANE_CLK];

  // Last pair of the clock symbol and the idle value are both ones
  assert_clk_last_pair_R5: assert property (@(posedge clk_fast) disable iff (rst_fast)
    sym_ready |-> (lane_clk == 2'b11));
  assert_ready_gap_R1: assert property (@(posedge clk_fast) disable iff (rst_fast)
    sym_ready |=> !sym_ready);
endmodule

// File: tb/tmds_ddr_gearbox_tb.sv
`timescale 1ns/1ps
module tmds_ddr_gearbox_tb;
  localparam int T = 8;
  localparam logic [9:0] CLK_SYM = 10'b1111100000;

  typedef struct packed {
    logic [9:0] b, g, r, c;
  } exp_t;

  logic clk = 0, rst = 1, sym_valid = 0;
  logic [9:0] sym_blue = '0, sym_green = '0, sym_red = '0;
  logic sym_ready;
  logic [1:0] lane_blue, lane_green, lane_red, lane_clk;

  int n_checks = 0, n_fail = 0;
  exp_t q[$];
  logic tb_loaded = 0;
  exp_t last_sym = '1;

  tmds_ddr_gearbox u_dut (
    .clk_fast(clk), .rst_fast(rst), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_blue(sym_blue), .sym_green(sym_green), .sym_red(sym_red),
    .lane_blue(lane_blue), .lane_green(lane_green), .lane_red(lane_red),
    .lane_clk(lane_clk)
  );

  always #(T/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: junk outside the ready slot, real data in it; expected pushed at the slot
  task automatic slot(input logic v, input logic [9:0] b, input logic [9:0] g, input logic [9:0] r);
    exp_t e;
    forever begin
      @(negedge clk); #(T/4);
      if (!sym_ready) begin
        sym_valid = 1'($urandom);
        sym_blue  = 10'($urandom);
        sym_green = 10'($urandom);
        sym_red   = 10'($urandom);
      end else begin
        sym_valid = v;
        sym_blue = b; sym_green = g; sym_red = r;
        if (v) begin
          tb_loaded = 1;
          last_sym = '{b: b, g: g, r: r, c: CLK_SYM};
        end
        e = tb_loaded ? last_sym : '1;
        q.push_back(e);
        break;
      end
    end
  endtask

  // Monitor: rebuild five pairs after each slot, check slot spacing
  initial begin
    int col = -1;
    int since = 0;
    logic [9:0] ab, ag, ar, ac;
    exp_t e;
    forever begin
      @(negedge clk); #(T/4);
      if (rst) begin
        col = -1; since = 0;
        continue;
      end
      since++;
      if (col >= 0) begin
        ab[2*col +: 2] = lane_blue;
        ag[2*col +: 2] = lane_green;
        ar[2*col +: 2] = lane_red;
        ac[2*col +: 2] = lane_clk;
        col++;
        if (col == 5) begin
          col = -1;
          if (q.size() == 0) begin
            check("R2 unexpected symbol", 32'd1, 32'd0);
          end else begin
            e = q.pop_front();
            check("R3 R8 blue lane", 32'(ab), 32'(e.b));
            check("R3 R8 green lane", 32'(ag), 32'(e.g));
            check("R3 R8 red lane", 32'(ar), 32'(e.r));
            check("R5 R4 clock lane", 32'(ac), 32'(e.c));
          end
        end
      end
      if (sym_ready) begin
        check("R1 ready spacing", 32'(since), 32'd5);
        since = 0;
        col = 0;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1; sym_valid = 0;
    repeat (3) @(negedge clk);
    #(T/4);
    check("R7 ready low in reset", 32'(sym_ready), 32'd0);
    check("R7 lanes ones in reset", 32'({lane_blue, lane_green, lane_red, lane_clk}), 32'hFF);
    q.delete();
    tb_loaded = 0;
    last_sym = '1;
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(T * 200000);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #(T/4);
    check("R4 reset lanes", 32'({lane_blue, lane_green, lane_red, lane_clk}), 32'hFF);
    check("R1 ready low in reset", 32'(sym_ready), 32'd0);
    @(negedge clk);
    rst = 0;
    #(T/4);
    check("R4 idle after release", 32'({lane_blue, lane_green, lane_red, lane_clk}), 32'hFF);
    // R4: idle slots before any capture
    slot(0, 10'h000, 10'h000, 10'h000);
    slot(0, 10'h155, 10'h2AA, 10'h0F0);
    // R3/R8: distinct patterns per channel
    slot(1, 10'h001, 10'h002, 10'h200);
    slot(1, 10'h155, 10'h2AA, 10'h3C3);
    slot(1, 10'h0F0, 10'h30F, 10'h0AA);
    for (int i = 0; i < 10; i++) slot(1, 10'(1 << i), 10'(~(1 << i)), 10'(i * 97));
    // R6: missed slots repeat the held symbol
    slot(1, 10'h123, 10'h234, 10'h345);
    slot(0, 10'h000, 10'h3FF, 10'h111);
    slot(0, 10'h222, 10'h000, 10'h333);
    slot(1, 10'h3FE, 10'h001, 10'h2D4);
    for (int i = 0; i < 20; i++) slot(1'($urandom), 10'($urandom), 10'($urandom), 10'($urandom));
    // R7: reset in the middle of a period
    repeat (2) @(negedge clk);
    do_reset();
    #(T/4);
    check("R7 R4 idle after mid reset", 32'({lane_blue, lane_green, lane_red, lane_clk}), 32'hFF);
    slot(0, 10'h000, 10'h000, 10'h000);
    slot(1, 10'h2C1, 10'h13E, 10'h0FF);
    slot(1, 10'h3FF, 10'h000, 10'h155);
    repeat (8) @(negedge clk);
    check("R2 queue drained", 32'(q.size()), 32'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule